// File: doc/BRIEF.md
# Mass-Storage Write Command Filter

This block sits on the host-to-drive command path of a storage bridge. It watches a byte stream that carries bulk-only command wrappers, one byte per cycle under a valid strobe, with a last strobe on the final byte. Each wrapper is held whole before any decision is made. The filter then looks at the SCSI operation code carried inside the wrapper. Commands that read, test or query the drive go out on the forwarded stream byte for byte. Commands that would change the media are dropped and never reach the drive side.

For a dropped command, the block emits a one-cycle notice. The notice carries the starting block address and the block count decoded from the command, so that downstream logic can drain and discard the matching host data. For every accepted wrapper, the block also produces a status code for the command status wrapper: failed for a dropped command, good for a forwarded one. A malformed wrapper is thrown away without any output.

Top module: `cwf_write_filter`

## Requirements
- R1: A synchronous active-high reset clears `out_valid`, `blk_pulse` and `sts_valid` to 0. It also returns the parser to wait for byte 0, so a wrapper cut off by reset is forgotten and the next full wrapper is handled normally.
- R2: A well-formed wrapper is exactly 31 bytes long, with `in_last` on byte 30. Bytes 0..3 are 0x55, 0x53, 0x42, 0x43 in that order. Byte 15 is the operation code, and bytes 15..30 are the command block (CB byte k is wrapper byte 15+k).
- R3: For any operation code other than 0x2A, 0x0A or 0x04 (including 0x28, 0x08, 0x00 and 0x03), all 31 bytes appear on `out_data` unchanged, in order, on consecutive cycles. `out_last` is high with byte 30 only. Byte 0 appears two clock edges after the edge at which the last input byte was driven.
- R4: For operation codes 0x2A, 0x0A and 0x04, no byte of the wrapper ever appears on the output.
- R5: A blocked command raises `blk_pulse` for exactly one cycle, at the cycle where forwarding would have begun. For 0x2A, `blk_lba` is CB bytes 2..5 (CB byte 2 most significant) and `blk_len` is CB bytes 7..8 (CB byte 7 most significant).
- R6: For 0x0A, `blk_lba` is {CB byte 1 bits 4:0, CB byte 2, CB byte 3} and `blk_len` is CB byte 4, where 0 means 256. For 0x04, both are 0.
- R7: Each well-formed wrapper gives one `sts_valid` cycle, in the same cycle as the block notice or the first forwarded byte. `sts_code` is 0x01 for a blocked command and 0x00 for a forwarded one.
- R8: A wrapper with any signature byte wrong gives no forwarded byte, no block notice and no status.
- R9: A wrapper that ends before byte 30, or runs past byte 30, is discarded with no output of any kind. The wrapper after it is handled normally.
- R10: A wrapper may start on the cycle right after the previous one ended. Its capture overlaps the forwarding of the previous wrapper, and both are handled correctly.
- R11: While `in_valid` is low, `in_data` and `in_last` are ignored, so idle cycles may appear anywhere inside a wrapper.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte strobe |
| in_data | input | 8 | Input wrapper byte |
| in_last | input | 1 | Marks final byte of a wrapper |
| out_valid | output | 1 | Forwarded byte strobe |
| out_data | output | 8 | Forwarded wrapper byte |
| out_last | output | 1 | Marks final forwarded byte |
| blk_pulse | output | 1 | One-cycle notice of a dropped command |
| blk_lba | output | 32 | Decoded start block of the dropped command |
| blk_len | output | 16 | Decoded block count of the dropped command |
| sts_valid | output | 1 | Status code strobe |
| sts_code | output | 8 | Status for the host: 0x00 good, 0x01 failed |

## Verification
The one overlap this block allows is between two functions: replaying a forwarded wrapper on the output, and capturing the next wrapper on the input. These fall in the same cycles whenever wrappers arrive with no idle cycle between them. The bench provokes this with two back-to-back pairs: a forwarded wrapper followed by another forwarded wrapper, and a forwarded wrapper followed by a write. The first pair is judged by comparing all 62 output bytes against both wrappers in order. The second pair is judged by the first wrapper's 31 bytes arriving intact, with exactly one block notice and decoded values for the write after it.

// File: rtl/cwf_pkg.sv
package cwf_pkg;

    localparam int          WRAP_BYTES = 31;
    localparam int          CB_OFFSET  = 15;
    localparam logic [31:0] WRAP_SIG   = 32'h4342_5355;

    localparam logic [7:0]  OP_WRITE10 = 8'h2A;
    localparam logic [7:0]  OP_WRITE6  = 8'h0A;
    localparam logic [7:0]  OP_FORMAT  = 8'h04;

    localparam logic [7:0]  STS_GOOD   = 8'h00;
    localparam logic [7:0]  STS_FAILED = 8'h01;

    typedef enum logic [1:0] {
        KIND_PASS,
        KIND_WR10,
        KIND_WR6,
        KIND_FMT
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e   kind;
        logic [31:0] lba;
        logic [15:0] len;
    } cmd_info_t;

    function automatic cmd_kind_e kind_of(input logic [7:0] opc);
        case (opc)
            OP_WRITE10: return KIND_WR10;
            OP_WRITE6:  return KIND_WR6;
            OP_FORMAT:  return KIND_FMT;
            default:    return KIND_PASS;
        endcase
    endfunction

endpackage

// File: rtl/cwf_capture.sv
module cwf_capture
    import cwf_pkg::*;
#(
    parameter int          NBYTES    = WRAP_BYTES,
    parameter logic [31:0] SIGNATURE = WRAP_SIG,
    localparam int         IW        = $clog2(NBYTES + 1),
    localparam int         FW        = NBYTES * 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    output logic          frame_ok,
    output logic [FW-1:0] frame
);

    logic [IW-1:0] idx;
    logic          sig_bad;
    logic          ovf;
    logic          hit_bad;

    always_comb begin
        hit_bad = (idx < IW'(4)) &&
                  (in_data != SIGNATURE[int'(idx[1:0]) * 8 +: 8]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx      <= '0;
            sig_bad  <= 1'b0;
            ovf      <= 1'b0;
            frame_ok <= 1'b0;
        end else begin
            frame_ok <= 1'b0;
            if (in_valid) begin
                frame[int'(idx) * 8 +: 8] <= in_data;
                if (in_last) begin
                    frame_ok <= (idx == IW'(NBYTES - 1)) && !sig_bad &&
                                !hit_bad && !ovf;
                    idx      <= '0;
                    sig_bad  <= 1'b0;
                    ovf      <= 1'b0;
                end else begin
                    sig_bad <= sig_bad | hit_bad;
                    if (idx == IW'(NBYTES - 1)) begin
                        ovf <= 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
            end
        end
    end

    AST_OK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        frame_ok |=> !frame_ok); // R2

endmodule

// File: rtl/cwf_classify.sv
module cwf_classify
    import cwf_pkg::*;
#(
    parameter int  CB_USED = 9,
    localparam int CW      = CB_USED * 8
) (
    input  logic [CW-1:0] cb,
    output cmd_info_t     info
);

    logic [7:0] b [CB_USED];
    logic       unused_hi;

    for (genvar k = 0; k < CB_USED; k++) begin : g_bytes
        assign b[k] = cb[k * 8 +: 8];
    end

    assign unused_hi = ^b[1][7:5];

    always_comb begin
        info.kind = kind_of(b[0]);
        info.lba  = '0;
        info.len  = '0;
        case (info.kind)
            KIND_WR10: begin
                info.lba = {b[2], b[3], b[4], b[5]};
                info.len = {b[7], b[8]};
            end
            KIND_WR6: begin
                info.lba = {11'd0, b[1][4:0], b[2], b[3]};
                info.len = (b[4] == 8'd0) ? 16'd256 : {8'd0, b[4]};
            end
            default: begin
                info.lba = '0;
                info.len = '0;
            end
        endcase
    end

endmodule

// File: rtl/cwf_replay.sv
module cwf_replay #(
    parameter int  NBYTES = 31,
    localparam int IW     = $clog2(NBYTES + 1),
    localparam int FW     = NBYTES * 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [FW-1:0] frame_in,
    output logic          out_valid,
    output logic [7:0]    out_data,
    output logic          out_last
);

    logic [FW-1:0] sh;
    logic [IW-1:0] rem;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_data  <= '0;
            rem       <= '0;
            sh        <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= frame_in[7:0];
            out_last  <= (NBYTES == 1);
            sh        <= frame_in >> 8;
            rem       <= IW'(NBYTES - 1);
        end else if (rem != '0) begin
            out_valid <= 1'b1;
            out_data  <= sh[7:0];
            out_last  <= (rem == IW'(1));
            sh        <= sh >> 8;
            rem       <= rem - 1'b1;
        end else begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
        end
    end

    AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        load |-> (rem == '0)); // R10

    AST_LAST_IS_VALID: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid); // R3

endmodule

// File: rtl/cwf_write_filter.sv
module cwf_write_filter
    import cwf_pkg::*;
#(
    parameter int  NBYTES  = WRAP_BYTES,
    parameter int  CB_OFS  = CB_OFFSET,
    localparam int CB_USED = 9,
    localparam int FW      = NBYTES * 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        out_last,
    output logic        blk_pulse,
    output logic [31:0] blk_lba,
    output logic [15:0] blk_len,
    output logic        sts_valid,
    output logic [7:0]  sts_code
);

    logic          frame_ok;
    logic [FW-1:0] frame;
    cmd_info_t     info;
    logic          fwd_load;

    cwf_capture #(.NBYTES(NBYTES), .SIGNATURE(WRAP_SIG)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_last  (in_last),
        .frame_ok (frame_ok),
        .frame    (frame)
    );

    cwf_classify #(.CB_USED(CB_USED)) u_cls (
        .cb   (frame[(CB_OFS + CB_USED) * 8 - 1 : CB_OFS * 8]),
        .info (info)
    );

    assign fwd_load = frame_ok && (info.kind == KIND_PASS);

    cwf_replay #(.NBYTES(NBYTES)) u_rep (
        .clk       (clk),
        .rst       (rst),
        .load      (fwd_load),
        .frame_in  (frame),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_pulse <= 1'b0;
            blk_lba   <= '0;
            blk_len   <= '0;
            sts_valid <= 1'b0;
            sts_code  <= STS_GOOD;
        end else begin
            blk_pulse <= 1'b0;
            sts_valid <= 1'b0;
            if (frame_ok) begin
                sts_valid <= 1'b1;
                if (info.kind != KIND_PASS) begin
                    blk_pulse <= 1'b1;
                    blk_lba   <= info.lba;
                    blk_len   <= info.len;
                    sts_code  <= STS_FAILED;
                end else begin
                    sts_code  <= STS_GOOD;
                end
            end
        end
    end

    AST_BLOCK_SILENT: assert property (@(posedge clk) disable iff (rst)
        blk_pulse |-> !out_valid); // R4

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        blk_pulse |=> !blk_pulse); // R5

    AST_FAIL_WITH_BLOCK: assert property (@(posedge clk) disable iff (rst)
        blk_pulse |-> (sts_valid && sts_code == STS_FAILED)); // R7

    AST_GOOD_WITH_FWD: assert property (@(posedge clk) disable iff (rst)
        (sts_valid && !blk_pulse) |-> (sts_code == STS_GOOD && out_valid)); // R7

endmodule

// File: tb/tb_cwf_write_filter.sv
`timescale 1ns/1ps
module tb_cwf_write_filter;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [7:0]  in_data;
    logic        in_last;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_last;
    logic        blk_pulse;
    logic [31:0] blk_lba;
    logic [15:0] blk_len;
    logic        sts_valid;
    logic [7:0]  sts_code;

    always #2.5 clk = ~clk;

    cwf_write_filter dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last), .blk_pulse(blk_pulse), .blk_lba(blk_lba),
        .blk_len(blk_len), .sts_valid(sts_valid), .sts_code(sts_code)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int last_drive = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor
    logic [7:0]  rx [0:79];
    int          rx_n, first_cyc, last_idx, last_cnt;
    int          blk_n, blk_cyc, sts_n;
    logic [31:0] m_lba;
    logic [15:0] m_len;
    logic [7:0]  m_sts;

    always @(negedge clk) begin
        if (out_valid) begin
            if (rx_n == 0) first_cyc = cyc;
            if (rx_n < 80) rx[rx_n] = out_data;
            if (out_last) begin
                last_idx = rx_n;
                last_cnt++;
            end
            rx_n++;
        end
        if (blk_pulse) begin
            blk_n++;
            blk_cyc = cyc;
            m_lba = blk_lba;
            m_len = blk_len;
        end
        if (sts_valid) begin
            sts_n++;
            m_sts = sts_code;
        end
    end

    task automatic clr_mon();
        rx_n = 0; first_cyc = -1; last_idx = -1; last_cnt = 0;
        blk_n = 0; blk_cyc = -1; sts_n = 0; m_lba = '0; m_len = '0;
        m_sts = 8'hFF;
    endtask

    task automatic chk(input bit ok, input string tag, input longint act,
                       input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // wrapper under construction and expected output stream
    logic [7:0] w   [0:40];
    logic [7:0] exq [0:79];
    int         exq_n;

    task automatic build(input logic [7:0] op, input logic [7:0] seed);
        for (int i = 0; i < 41; i++) w[i] = seed + 8'(i * 7);
        w[0] = 8'h55; w[1] = 8'h53; w[2] = 8'h42; w[3] = 8'h43;
        w[14] = 8'd10;
        w[15] = op;
    endtask

    task automatic push_exp();
        for (int i = 0; i < 31; i++) exq[exq_n + i] = w[i];
        exq_n += 31;
    endtask

    task automatic send(input int n, input bit gaps);
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 4 == 2)) begin
                @(posedge clk); #1;
                in_valid = 1'b0; in_data = 8'hEE; in_last = 1'b1;
            end
            @(posedge clk); #1;
            in_valid = 1'b1; in_data = w[i]; in_last = (i == n - 1);
            last_drive = cyc;
        end
    endtask

    task automatic idle_wait(input int n);
        @(posedge clk); #1;
        in_valid = 1'b0; in_last = 1'b0; in_data = 8'h00;
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic bit is_write(input logic [7:0] op);
        return (op == 8'h2A) || (op == 8'h0A) || (op == 8'h04);
    endfunction

    function automatic logic [31:0] exp_lba(input logic [7:0] op);
        if (op == 8'h2A) return {w[17], w[18], w[19], w[20]};
        if (op == 8'h0A) return {11'd0, w[16][4:0], w[17], w[18]};
        return 32'd0;
    endfunction

    function automatic logic [15:0] exp_len(input logic [7:0] op);
        if (op == 8'h2A) return {w[22], w[23]};
        if (op == 8'h0A) return (w[19] == 8'd0) ? 16'd256 : {8'd0, w[19]};
        return 16'd0;
    endfunction

    function automatic int mism(input int n);
        int m = 0;
        for (int i = 0; i < n; i++) if (rx[i] !== exq[i]) m++;
        return m;
    endfunction

    task automatic judge(input logic [7:0] op);
        if (is_write(op)) begin
            chk(rx_n == 0, "R4 no bytes forwarded for write", rx_n, 0);
            chk(blk_n == 1, "R5 one block pulse", blk_n, 1);
            chk(blk_cyc == last_drive + 2, "R5 pulse timing", blk_cyc, last_drive + 2);
            chk(m_lba == exp_lba(op), "R5 R6 block lba", m_lba, exp_lba(op));
            chk(m_len == exp_len(op), "R5 R6 block length", m_len, exp_len(op));
            chk(sts_n == 1 && m_sts == 8'h01, "R7 failed status", m_sts, 8'h01);
        end else begin
            chk(rx_n == 31, "R3 forwarded byte count", rx_n, 31);
            chk(mism(31) == 0, "R3 forwarded bytes unchanged", mism(31), 0);
            chk(last_cnt == 1 && last_idx == 30, "R3 last marker", last_idx, 30);
            chk(first_cyc == last_drive + 2, "R3 forward timing", first_cyc, last_drive + 2);
            chk(blk_n == 0, "R3 no block pulse", blk_n, 0);
            chk(sts_n == 1 && m_sts == 8'h00, "R7 good status", m_sts, 8'h00);
        end
    endtask

    localparam int NV = 9;
    localparam logic [7:0] VOP  [NV] = '{8'h28, 8'h08, 8'h00, 8'h03, 8'h2A,
                                         8'h0A, 8'h04, 8'h12, 8'h2A};
    localparam logic [7:0] VSEED[NV] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55,
                                         8'h66, 8'h77, 8'h88, 8'hF0};

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_data = '0; in_last = 1'b0;
        exq_n = 0;
        clr_mon();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(!out_valid && !blk_pulse && !sts_valid, "R1 reset outputs quiet",
            {out_valid, blk_pulse, sts_valid}, 0);

        // table walk, R2 R3 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            clr_mon(); exq_n = 0;
            build(VOP[v], VSEED[v]); push_exp();
            send(31, 1'b0);
            idle_wait(40);
            judge(VOP[v]);
        end

        // R6 WRITE(6) with zero length means 256
        clr_mon(); exq_n = 0;
        build(8'h0A, 8'h5A); w[19] = 8'h00;
        send(31, 1'b0); idle_wait(40);
        judge(8'h0A);
        chk(m_len == 16'd256, "R6 zero length is 256", m_len, 256);

        // R11 idle cycles with junk on data and last
        clr_mon(); exq_n = 0;
        build(8'h28, 8'h3C); push_exp();
        send(31, 1'b1); idle_wait(40);
        judge(8'h28);

        // R8 bad signature
        clr_mon();
        build(8'h28, 8'h10); w[2] = 8'h41;
        send(31, 1'b0); idle_wait(40);
        chk(rx_n == 0 && blk_n == 0 && sts_n == 0, "R8 bad signature silent",
            rx_n + blk_n + sts_n, 0);
        clr_mon();
        build(8'h2A, 8'h10); w[0] = 8'h54;
        send(31, 1'b0); idle_wait(40);
        chk(rx_n == 0 && blk_n == 0 && sts_n == 0, "R8 bad signature write silent",
            rx_n + blk_n + sts_n, 0);

        // R9 short and long wrappers, then a normal one
        clr_mon();
        build(8'h28, 8'h20);
        send(20, 1'b0); idle_wait(40);
        chk(rx_n == 0 && sts_n == 0, "R9 short wrapper dropped", rx_n + sts_n, 0);
        clr_mon();
        build(8'h2A, 8'h20);
        send(33, 1'b0); idle_wait(40);
        chk(rx_n == 0 && blk_n == 0 && sts_n == 0, "R9 long wrapper dropped",
            rx_n + blk_n + sts_n, 0);
        clr_mon(); exq_n = 0;
        build(8'h08, 8'h21); push_exp();
        send(31, 1'b0); idle_wait(40);
        judge(8'h08);

        // R10 back to back: forward then forward
        clr_mon(); exq_n = 0;
        build(8'h28, 8'h31); push_exp(); send(31, 1'b0);
        build(8'h00, 8'h41); push_exp(); send(31, 1'b0);
        idle_wait(40);
        chk(rx_n == 62, "R10 two forwarded wrappers count", rx_n, 62);
        chk(mism(62) == 0, "R10 two forwarded wrappers bytes", mism(62), 0);
        chk(sts_n == 2 && blk_n == 0, "R10 two good statuses", sts_n, 2);

        // R10 back to back: forward then write
        clr_mon(); exq_n = 0;
        build(8'h03, 8'h51); push_exp(); send(31, 1'b0);
        build(8'h2A, 8'h61); send(31, 1'b0);
        idle_wait(40);
        chk(rx_n == 31 && mism(31) == 0, "R10 forwarded then blocked bytes", rx_n, 31);
        chk(blk_n == 1 && m_lba == exp_lba(8'h2A) && m_len == exp_len(8'h2A),
            "R10 blocked after forward", m_lba, exp_lba(8'h2A));

        // R1 reset mid-wrapper
        clr_mon(); exq_n = 0;
        build(8'h2A, 8'h70);
        send(10, 1'b0);
        @(posedge clk); #1 in_valid = 1'b0; rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        build(8'h28, 8'h71); push_exp();
        send(31, 1'b0); idle_wait(40);
        chk(blk_n == 0, "R1 partial wrapper forgotten", blk_n, 0);
        judge(8'h28);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule